// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one 32-bit timer channel behind a small word-indexed register port. Software sets a reload constant, may load the down counter directly, and picks a count rate from a prescaler that divides the peripheral clock. The counter counts only while the external `start` input is high. It counts down by one on each prescaled tick. When a tick finds the counter at zero, the counter takes the reload constant in that same cycle and a sticky underflow flag is set. The interrupt output is that flag gated by an enable bit in the control register.

The prescaler is a free-running divider. It produces single-cycle enable pulses, so no derived clocks exist. Software clears the flag by writing the control register with the flag bit low. Writing the flag bit high leaves the flag as it is, so software can never set it.

Top module: `reload_timer`

## Requirements
- R1: After reset the reload constant reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, the control register reads 0, and `irq` is low.
- R2: Word index 0 is the reload constant, 1 is the counter and 2 is control. Index 3 reads as zero, and writes to it change no register.
- R3: Control holds the rate code in bits [2:0] and the interrupt enable in bit 5. It reads back the underflow flag in bit 8. Every other bit reads zero and ignores writes.
- R4: Rate codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clock cycles. The ticks come from a divider that runs freely from reset and is not restarted by register writes. Codes 5 to 7 give no ticks.
- R5: The counter decrements by one per tick only while `start` is high. While `start` is low the counter holds its value.
- R6: A tick that finds the counter at zero, with `start` high, loads the reload constant into the counter in that cycle and sets the flag. A reload value of N therefore gives an underflow every N+1 ticks.
- R7: Writing the reload constant only changes the value taken at the next underflow. Writing the counter loads it at once, and that write takes priority over a tick in the same cycle.
- R8: The flag is sticky. A control write with bit 8 low clears it, and a write with bit 8 high leaves it unchanged. If an underflow and a clearing write fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the flag is set and control bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; also the prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| start | input | 1 | Count enable for the channel |
| irq | output | 1 | Underflow interrupt |

## Verification
The checks assume that `start`, `wr_en`, `addr` and `wdata` are synchronous to `clk` and never change near its rising edge. The bench drives them only on falling edges. The bench avoids a clearing write in the exact cycle of an underflow, except where that overlap is the point of the check. It keeps control writes well inside a reload period, so period measurements rest on a known count of prescaled ticks.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             start,
  output logic             irq
);
  localparam int DIV_W = 10;
  localparam int FLAG_B = 8;
  localparam int IE_B = 5;

  logic [CNT_W-1:0] reload, cnt;
  logic [2:0]       rate;
  logic             ie, flag;
  logic [DIV_W-1:0] div, mask;
  logic             rate_ok, tick, run_tick, uflow;

  wire wr_rel = wr_en && addr == 2'd0;
  wire wr_cnt = wr_en && addr == 2'd1;
  wire wr_ctl = wr_en && addr == 2'd2;

  always_comb begin
    rate_ok = 1'b1;
    case (rate)
      3'd0: mask = 10'h003;
      3'd1: mask = 10'h00F;
      3'd2: mask = 10'h03F;
      3'd3: mask = 10'h0FF;
      3'd4: mask = 10'h3FF;
      default: begin mask = '0; rate_ok = 1'b0; end
    endcase
  end

  assign tick     = rate_ok && ((div & mask) == mask);
  assign run_tick = start && tick;
  assign uflow    = run_tick && cnt == '0 && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          reload <= '1;
    else if (wr_rel)     reload <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '1;
    else if (wr_cnt)     cnt <= wdata;
    else if (uflow)      cnt <= reload;
    else if (run_tick)   cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rate <= '0;
      ie   <= 1'b0;
    end else if (wr_ctl) begin
      rate <= wdata[2:0];
      ie   <= wdata[IE_B];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        flag <= 1'b0;
    else if (uflow)                    flag <= 1'b1;
    else if (wr_ctl && !wdata[FLAG_B]) flag <= 1'b0;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = reload;
      2'd1: rdata = cnt;
      2'd2: begin
        rdata[2:0]    = rate;
        rdata[IE_B]   = ie;
        rdata[FLAG_B] = flag;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = flag && ie;
endmodule

module reload_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             start,
  input logic             irq,
  input logic             tick,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  // R6
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(start) && $past(tick) && $past(cnt) == '0);
  // R5
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(wr_en && addr == 2'd1)) |=> $stable(cnt));
  // R6
  reload_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tick && cnt == '0 && !(wr_en && addr == 2'd1)) |=> cnt == $past(reload) && flag);
  // R7
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> cnt == $past(wdata));
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !wdata[5]) |=> !irq);
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 2'd2 && !wdata[8])) |=> flag);
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .start(start), .irq(irq), .tick(tick), .flag(flag), .cnt(cnt), .reload(reload)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  longint cyc = 0;

  reload_timer u_reload_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .start(start), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {index, write data, expected read-back}
  localparam logic [65:0] VEC [6] = '{
    {2'd0, 32'h0000_1234, 32'h0000_1234},   // R2
    {2'd1, 32'h0000_ABCD, 32'h0000_ABCD},   // R2 R7
    {2'd3, 32'hDEAD_BEEF, 32'h0000_0000},   // R2
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0027},   // R3 R8 write-one cannot set
    {2'd2, 32'h0000_0104, 32'h0000_0004},   // R3
    {2'd2, 32'h0000_0000, 32'h0000_0000}    // R3
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_flag(output longint t);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); rd(2'd2, v);
      if (v[8]) break;
    end
    t = cyc;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1;
    longint t1, t2, t3, t4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R1 counter", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][65:64], VEC[i][63:32]);
      @(negedge clk); rd(VEC[i][65:64], v);
      check($sformatf("R2/R3 vector %0d", i), v, VEC[i][31:0]);
    end
    // R2 index 3 write left the others alone
    rd(2'd0, v); check("R2 reload after idx3", v, 32'h0000_1234);
    rd(2'd1, v); check("R2 counter after idx3", v, 32'h0000_ABCD);

    // R6 period and reload on underflow at rate /4
    wr(2'd0, 32'd5); wr(2'd1, 32'd2); wr(2'd2, 32'h0);
    start = 1'b1;
    wait_flag(t1);
    rd(2'd1, v); check("R6 reload at underflow", v, 32'd5);
    check("R9 irq off with enable low", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h100);
    @(negedge clk); rd(2'd2, v); check("R8 write-one keeps flag", v, 32'h100);
    wr(2'd2, 32'h120);
    @(negedge clk); check("R9 irq with flag and enable", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h020);
    @(negedge clk); check("R8 clear flag / R9 irq low", {31'b0, irq}, 32'h0);
    wait_flag(t2);
    check("R6 period of six ticks", 32'(t2 - t1), 32'd24);
    // R7 reload write takes effect only at next underflow
    wr(2'd0, 32'd1); wr(2'd2, 32'h020);
    wait_flag(t3);
    check("R7 current period unchanged", 32'(t3 - t2), 32'd24);
    wr(2'd2, 32'h020);
    wait_flag(t4);
    check("R7 new reload period", 32'(t4 - t3), 32'd8);

    // R5 hold while stopped
    start = 1'b0;
    wr(2'd1, 32'd1000);
    @(negedge clk); rd(2'd1, c0);
    repeat (40) @(negedge clk);
    rd(2'd1, c1); check("R5 hold when stopped", c1, c0);

    // R4 rate /16
    wr(2'd2, 32'h1); start = 1'b1;
    @(negedge clk); rd(2'd1, c0);
    repeat (64) @(negedge clk);
    rd(2'd1, c1); check("R4 /16 ticks in 64 cycles", c0 - c1, 32'd4);
    // R4 rate /1024
    wr(2'd2, 32'h4);
    @(negedge clk); rd(2'd1, c0);
    repeat (2048) @(negedge clk);
    rd(2'd1, c1); check("R4 /1024 ticks in 2048 cycles", c0 - c1, 32'd2);
    // R4 reserved code gives no ticks
    wr(2'd2, 32'h5);
    @(negedge clk); rd(2'd1, c0);
    repeat (2048) @(negedge clk);
    rd(2'd1, c1); check("R4 reserved code holds", c1, c0);
    start = 1'b0;
    finish_run();
  end
endmodule